// File: doc/BRIEF.md
# Indirect Register Access Port for a Voice Codec Controller

This block is the byte-wide processor-facing register port of a voice codec controller. A few direct byte addresses are decoded. One of them is a command location. A write there selects one of a wide space of internal register numbers. The processor then moves the bytes of that register, one at a time, through a single data location. Two-byte registers are loaded low byte first, then high byte. The same command address, when read, returns the pending interrupt sources and clears them in that access.

The block holds several internal registers:
- the init register, which idles the device, activates it, and masks its interrupt output;
- the multiplexer control register, which enables the per-sample data interrupt;
- the channel routing register;
- the codec mode register, which selects the companding law and turns gain stages on;
- a parameterised bank of 16-bit gain registers.

A separate direct address exchanges one voice byte per 8 kHz sample period with the serial side.

Top module: `codec_regport`

## Requirements
- R1: After reset the pending status is 0x00, irq is low, bb_tx_out is 0x00, every gain register is 0x0000, and the mode, routing and init registers are 0x00.
- R2: A read of direct offset 0 returns the pending bitmask and clears it in the same access. A source event that arrives in the same cycle as that read stays pending after it.
- R3: Pending bit 4 (0x10) is set by a sample_tick only while internal register 0x44 has bit 3 (0x08) set. The evt_in input never sets bit 4. Any other evt_in bit k sets pending bit k.
- R4: irq is high exactly when some pending bit is set, init register 0x21 has bit 0 (0x01, active) set, and bit 2 (0x04, mask) is clear. Value 0x00 (idle) keeps irq low.
- R5: A write to offset 0 selects an internal register and resets its byte index to 0. For the gain registers 0x63+k, the next two writes to offset 1 load bits 7:0 and then bits 15:8 of gain_bus[16k+15:16k].
- R6: Data writes beyond the selected register's length (2 bytes for gains, 1 byte otherwise) are ignored. Writes to unimplemented register numbers are ignored.
- R7: Reads of offset 1 return the selected register's bytes low byte first. A read beyond the register's length, or of an unimplemented register number, returns 0x00.
- R8: Internal register 0x41 drives route_src from bits 3:0 and route_dst from bits 7:4.
- R9: Mode register 0x69 drives alaw_sel from bit 0. It drives stage_en[0..3] from bits 1, 2, 3 and 6 (transmit, receive, extra receive and sidetone gain).
- R10: A write to offset 5 sets bb_tx_out, which is otherwise held. A read of offset 5 returns the bb_rx_in byte captured at the most recent sample_tick.
- R11: Writes to offsets 2, 3, 4, 6 and 7 change nothing, and reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Access select |
| wr | input | 1 | Write strobe (with cs) |
| rd | input | 1 | Read strobe (with cs) |
| addr | input | 3 | Direct byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| evt_in | input | 8 | One-cycle event pulses from the other interrupt sources |
| sample_tick | input | 1 | One pulse per 8 kHz sample period |
| bb_rx_in | input | 8 | Received voice byte from the serial side |
| bb_tx_out | output | 8 | Voice byte to transmit |
| irq | output | 1 | Interrupt request |
| alaw_sel | output | 1 | 1 selects A-law, 0 selects mu-law |
| stage_en | output | 4 | Gain stage enables: tx, rx, extra rx, sidetone |
| route_src | output | 4 | Routing source code |
| route_dst | output | 4 | Routing destination code |
| gain_bus | output | 64 | Gain registers, 16 bits each |

## Verification
Every write takes effect at the clock edge that ends its access. Register outputs, irq and bb_tx_out are therefore compared at the falling edge that follows that access. rdata is combinational, so its value is captured during the read cycle, before the edge that clears the status or advances the byte index. An event pulse is visible in irq one edge later. The same-cycle clear case drives the read and a new event together, then reads the status again to confirm the event survived.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;
   // direct byte offsets
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_DATA = 3'd1;
   localparam logic [2:0] OFS_BB   = 3'd5;
   // internal register numbers
   localparam logic [7:0] IREG_INIT  = 8'h21;
   localparam logic [7:0] IREG_ROUTE = 8'h41;
   localparam logic [7:0] IREG_MUXC  = 8'h44;
   localparam logic [7:0] IREG_MODE  = 8'h69;
   // field positions
   localparam int INIT_ACT_BIT  = 0;
   localparam int INIT_MASK_BIT = 2;
   localparam int MUXC_BINT_BIT = 3;
   localparam int STAT_BBUF_BIT = 4;
endpackage

// File: rtl/regport_status.sv
module regport_status #(
   parameter int W        = 8,
   parameter int BBUF_BIT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_in,
   input  logic         tick,
   input  logic         bint_en,
   input  logic         clr,
   output logic [W-1:0] pend
);
   localparam logic [W-1:0] BBUF_MASK = W'(1) << BBUF_BIT;

   generate
      if (BBUF_BIT >= W) begin : g_bad
         $error("BBUF_BIT outside the status width");
      end
   endgenerate

   logic [W-1:0] set_v;
   always_comb begin
      set_v = evt_in & ~BBUF_MASK;
      if (tick && bint_en) set_v = set_v | BBUF_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (clr ? '0 : pend) | set_v;
   end
endmodule

// File: rtl/regport_ifile.sv
module regport_ifile
   import codec_regport_pkg::*;
#(
   parameter int         GAIN_N    = 4,
   parameter logic [7:0] GAIN_BASE = 8'h63
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_we,
   input  logic [7:0]           cmd_val,
   input  logic                 dat_we,
   input  logic                 dat_re,
   input  logic [7:0]           dat_wval,
   output logic [7:0]           dat_rval,
   output logic [1:0]           idx_o,
   output logic [7:0]           init_q,
   output logic [7:0]           muxc_q,
   output logic [7:0]           route_q,
   output logic [7:0]           mode_q,
   output logic [GAIN_N*16-1:0] gain_flat
);
   localparam int GAIN_LAST = int'(GAIN_BASE) + GAIN_N - 1;

   generate
      if (GAIN_N < 1 || GAIN_LAST > 255) begin : g_bad
         $error("gain bank does not fit the register space");
      end
   endgenerate

   logic [7:0] sel_q;
   logic [1:0] idx_q;
   logic [1:0] len;
   logic       is_gain;
   logic       has_byte;
   logic [7:0] gsel;
   logic [15:0] gain_q [GAIN_N];

   always_comb begin
      gsel    = sel_q - GAIN_BASE;
      is_gain = (int'(sel_q) >= int'(GAIN_BASE)) && (int'(sel_q) <= GAIN_LAST);
      if (is_gain) len = 2'd2;
      else if (sel_q == IREG_INIT || sel_q == IREG_ROUTE ||
               sel_q == IREG_MUXC || sel_q == IREG_MODE) len = 2'd1;
      else len = 2'd0;
      has_byte = idx_q < len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         idx_q <= '0;
      end else if (cmd_we) begin
         sel_q <= cmd_val;
         idx_q <= '0;
      end else if ((dat_we || dat_re) && has_byte) begin
         idx_q <= idx_q + 2'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q  <= '0;
         muxc_q  <= '0;
         route_q <= '0;
         mode_q  <= '0;
      end else if (dat_we && has_byte) begin
         case (sel_q)
            IREG_INIT:  init_q  <= dat_wval;
            IREG_MUXC:  muxc_q  <= dat_wval;
            IREG_ROUTE: route_q <= dat_wval;
            IREG_MODE:  mode_q  <= dat_wval;
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < GAIN_N; k++) begin : g_gain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gain_q[k] <= '0;
         else if (dat_we && has_byte && is_gain && gsel == 8'(k)) begin
            if (idx_q[0]) gain_q[k][15:8] <= dat_wval;
            else          gain_q[k][7:0]  <= dat_wval;
         end
      end
      assign gain_flat[k*16 +: 16] = gain_q[k];
   end

   always_comb begin
      dat_rval = '0;
      if (has_byte) begin
         if (is_gain) begin
            for (int k = 0; k < GAIN_N; k++)
               if (gsel == 8'(k))
                  dat_rval = idx_q[0] ? gain_q[k][15:8] : gain_q[k][7:0];
         end else begin
            case (sel_q)
               IREG_INIT:  dat_rval = init_q;
               IREG_MUXC:  dat_rval = muxc_q;
               IREG_ROUTE: dat_rval = route_q;
               IREG_MODE:  dat_rval = mode_q;
               default:    dat_rval = '0;
            endcase
         end
      end
   end

   assign idx_o = idx_q;
endmodule

// File: rtl/regport_voice.sv
module regport_voice #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_we,
   input  logic [DW-1:0] tx_val,
   input  logic          tick,
   input  logic [DW-1:0] rx_in,
   output logic [DW-1:0] tx_q,
   output logic [DW-1:0] rx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (tx_we) tx_q <= tx_val;
         if (tick)  rx_q <= rx_in;
      end
   end
endmodule

// File: rtl/codec_regport.sv
module codec_regport
   import codec_regport_pkg::*;
#(
   parameter int         GAIN_N    = 4,
   parameter logic [7:0] GAIN_BASE = 8'h63
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs,
   input  logic                 wr,
   input  logic                 rd,
   input  logic [2:0]           addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata,
   input  logic [7:0]           evt_in,
   input  logic                 sample_tick,
   input  logic [7:0]           bb_rx_in,
   output logic [7:0]           bb_tx_out,
   output logic                 irq,
   output logic                 alaw_sel,
   output logic [3:0]           stage_en,
   output logic [3:0]           route_src,
   output logic [3:0]           route_dst,
   output logic [GAIN_N*16-1:0] gain_bus
);
   logic       wacc, racc;
   logic [7:0] pend, dat_rval, init_q, muxc_q, route_q, mode_q, rx_q;
   logic [1:0] idx;
   logic       bint_en;

   assign wacc = cs && wr;
   assign racc = cs && rd;
   assign bint_en = muxc_q[MUXC_BINT_BIT];

   regport_status #(.W(8), .BBUF_BIT(STAT_BBUF_BIT)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick(sample_tick),
      .bint_en(bint_en), .clr(racc && addr == OFS_CMD), .pend(pend));

   regport_ifile #(.GAIN_N(GAIN_N), .GAIN_BASE(GAIN_BASE)) u_ifile (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(wacc && addr == OFS_CMD), .cmd_val(wdata),
      .dat_we(wacc && addr == OFS_DATA), .dat_re(racc && addr == OFS_DATA),
      .dat_wval(wdata), .dat_rval(dat_rval), .idx_o(idx),
      .init_q(init_q), .muxc_q(muxc_q), .route_q(route_q), .mode_q(mode_q),
      .gain_flat(gain_bus));

   regport_voice #(.DW(8)) u_voice (
      .clk(clk), .rst_n(rst_n), .tx_we(wacc && addr == OFS_BB), .tx_val(wdata),
      .tick(sample_tick), .rx_in(bb_rx_in), .tx_q(bb_tx_out), .rx_q(rx_q));

   always_comb begin
      case (addr)
         OFS_CMD:  rdata = pend;
         OFS_DATA: rdata = dat_rval;
         OFS_BB:   rdata = rx_q;
         default:  rdata = '0;
      endcase
   end

   assign irq       = (|pend) && init_q[INIT_ACT_BIT] && !init_q[INIT_MASK_BIT];
   assign alaw_sel  = mode_q[0];
   assign stage_en  = {mode_q[6], mode_q[3], mode_q[2], mode_q[1]};
   assign route_src = route_q[3:0];
   assign route_dst = route_q[7:4];
endmodule

// File: rtl/codec_regport_chk.sv
module codec_regport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs,
   input logic       wr,
   input logic       rd,
   input logic [2:0] addr,
   input logic [7:0] evt_in,
   input logic       sample_tick,
   input logic       irq,
   input logic [7:0] bb_tx_out,
   input logic [7:0] pend,
   input logic       bint_en,
   input logic [1:0] idx
);
   // R2
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && addr == 3'd0 && evt_in == 8'h00 && !sample_tick) |=> (pend == 8'h00));
   // R3
   bbuf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[4]) |-> $past(sample_tick && bint_en));
   // R4
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend != 8'h00));
   // R5
   idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 3'd0) |=> (idx == 2'd0));
   // R6
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= 2'd2);
   // R10
   bbtx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr && addr == 3'd5) |=> $stable(bb_tx_out));
endmodule

bind codec_regport codec_regport_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
   .evt_in(evt_in), .sample_tick(sample_tick), .irq(irq),
   .bb_tx_out(bb_tx_out), .pend(pend), .bint_en(bint_en), .idx(idx));

// File: tb/test_codec_regport.sv
module test_codec_regport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 0, wr = 0, rd = 0, sample_tick = 0;
   logic [2:0]  addr = 0;
   logic [7:0]  wdata = 0, evt_in = 0, bb_rx_in = 0;
   logic [7:0]  rdata, bb_tx_out;
   logic        irq, alaw_sel;
   logic [3:0]  stage_en, route_src, route_dst;
   logic [63:0] gain_bus;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   codec_regport i_codec_regport (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .sample_tick(sample_tick),
      .bb_rx_in(bb_rx_in), .bb_tx_out(bb_tx_out), .irq(irq), .alaw_sel(alaw_sel),
      .stage_en(stage_en), .route_src(route_src), .route_dst(route_dst),
      .gain_bus(gain_bus));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); cs = 0; wr = 0;
   endtask

   task automatic rd_b(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); cs = 1; rd = 1; addr = a;
      #1 d = rdata;
      @(negedge clk); cs = 0; rd = 0;
   endtask

   task automatic pulse_evt(input logic [7:0] e);
      @(negedge clk); evt_in = e;
      @(negedge clk); evt_in = 0;
   endtask

   task automatic pulse_tick(input logic [7:0] rx);
      @(negedge clk); sample_tick = 1; bb_rx_in = rx;
      @(negedge clk); sample_tick = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 irq", irq, 0);
      chk("R1 bb_tx", bb_tx_out, 0);
      chk("R1 gains", gain_bus, 0);
      chk("R1 mode/route", {alaw_sel, stage_en, route_src, route_dst}, 0);
      rd_b(3'd0, d); chk("R1 status", d, 8'h00);
   endtask

   task automatic t_gain();
      logic [7:0] d;
      wr_b(0, 8'h64); wr_b(1, 8'h34); wr_b(1, 8'h12); wr_b(1, 8'h99);
      chk("R5 gain1 low/high", gain_bus[31:16], 16'h1234);
      chk("R6 extra byte ignored", gain_bus[31:16], 16'h1234);
      chk("R6 other gains untouched", {gain_bus[63:32], gain_bus[15:0]}, 0);
      wr_b(0, 8'h64); rd_b(1, d); chk("R7 read low", d, 8'h34);
      rd_b(1, d); chk("R7 read high", d, 8'h12);
      rd_b(1, d); chk("R7 read past end", d, 8'h00);
      wr_b(0, 8'h66); wr_b(1, 8'hAA); wr_b(0, 8'h66); wr_b(1, 8'h55); wr_b(1, 8'h66);
      chk("R5 index restarts on command", gain_bus[63:48], 16'h6655);
      wr_b(0, 8'h50); wr_b(1, 8'h77); rd_b(1, d);
      chk("R7 unimplemented reads zero", d, 8'h00);
      chk("R6 unimplemented write ignored", gain_bus[47:0], 48'h0000_1234_0000);
   endtask

   task automatic t_route_mode();
      wr_b(0, 8'h41); wr_b(1, 8'h43);
      chk("R8 route", {route_dst, route_src}, 8'h43);
      wr_b(0, 8'h69); wr_b(1, 8'h4F);
      chk("R9 alaw", alaw_sel, 1);
      chk("R9 stages all", stage_en, 4'b1111);
      wr_b(0, 8'h69); wr_b(1, 8'h02);
      chk("R9 mu-law tx only", {alaw_sel, stage_en}, 5'b0_0001);
      wr_b(0, 8'h69); wr_b(1, 8'h44);
      chk("R9 rx+side", stage_en, 4'b1010);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr_b(0, 8'h21); wr_b(1, 8'h01);
      pulse_evt(8'h01);
      chk("R4 irq active", irq, 1);
      rd_b(0, d); chk("R2 status value", d, 8'h01);
      chk("R2 cleared irq", irq, 0);
      rd_b(0, d); chk("R2 status cleared", d, 8'h00);
      wr_b(0, 8'h21); wr_b(1, 8'h05);
      pulse_evt(8'h20);
      chk("R4 masked irq", irq, 0);
      rd_b(0, d); chk("R3 bit5 from evt", d, 8'h20);
      wr_b(0, 8'h21); wr_b(1, 8'h00);
      pulse_evt(8'h80);
      chk("R4 idle irq", irq, 0);
      rd_b(0, d); chk("R3 bit7 from evt", d, 8'h80);
      pulse_evt(8'h10);
      rd_b(0, d); chk("R3 evt bit4 ignored", d, 8'h00);
      pulse_tick(8'h00);
      rd_b(0, d); chk("R3 tick without enable", d, 8'h00);
      wr_b(0, 8'h44); wr_b(1, 8'h08);
      pulse_tick(8'h00);
      rd_b(0, d); chk("R3 tick with enable", d, 8'h10);
      wr_b(0, 8'h44); wr_b(1, 8'h00);
      pulse_evt(8'h04);
      @(negedge clk); cs = 1; rd = 1; addr = 0; evt_in = 8'h02;
      #1 d = rdata;
      @(negedge clk); cs = 0; rd = 0; evt_in = 0;
      chk("R2 read sees prior", d, 8'h04);
      rd_b(0, d); chk("R2 same-cycle event kept", d, 8'h02);
   endtask

   task automatic t_voice();
      logic [7:0] d;
      wr_b(5, 8'hC3);
      chk("R10 tx byte", bb_tx_out, 8'hC3);
      pulse_tick(8'h5A);
      @(negedge clk); bb_rx_in = 8'hEE;
      rd_b(5, d); chk("R10 rx byte held", d, 8'h5A);
      chk("R10 tx held", bb_tx_out, 8'hC3);
   endtask

   task automatic t_unused();
      logic [7:0] d;
      wr_b(3, 8'hFF); wr_b(2, 8'hFF); wr_b(7, 8'hFF);
      chk("R11 tx unchanged", bb_tx_out, 8'hC3);
      chk("R11 gains unchanged", gain_bus, 64'h6655_0000_1234_0000);
      chk("R11 route unchanged", {route_dst, route_src}, 8'h43);
      rd_b(3, d); chk("R11 read zero", d, 8'h00);
      rd_b(0, d); chk("R11 no status", d, 8'h00);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_gain();
      t_route_mode();
      t_irq();
      t_voice();
      t_unused();
      summary();
      $finish;
   end
endmodule